// File: doc/BRIEF.md
# Shadow-Register X-Canceling Signature Compactor

This block compacts scan-out data that may contain unknown values, and it never asks the scan chains to pause. Each cycle a slice of scan outputs passes through a fixed phase-shifting XOR network. The result is folded into a signature register built as a linear-feedback multiple-input shift register. When the tester raises the transfer input, the running signature is copied into a shadow register. In the same cycle the main register restarts from an all-zero state, so compaction of the next window goes on without a gap.

While the next window builds up, several independent selective-XOR channels read the held shadow value. Each channel has its own mask input, supplied by the tester. It returns the parity of the shadow bits that the mask selects. Test software picks masks whose selected bits cancel every unknown symbol in the window, which makes each check bit deterministic and comparable against a fault-free value. Check bits are registered once before they leave the block. A valid flag stays low until the shadow register has received its first signature.

Top module: `xc_shadow_compactor`

## Requirements
- R1: While reset is asserted and after its release, before any transfer, `chk_valid` is 0 and every bit of `chk_bits` is 0.
- R2: With 8 chains and a 16-bit signature, the phase-shifted word P has bit j equal to scan_in[j mod 8] XOR scan_in[(5j+3) mod 8]. On a cycle without transfer, the signature S advances to {S[14:0], parity(S AND 16'hB400)} XOR P.
- R3: On a transfer cycle, the shadow register takes the signature value from before that edge, and the signature becomes exactly P of that same cycle. That slice therefore belongs to the new window, and this also holds for transfers on back-to-back cycles.
- R4: The shadow register keeps its value on every cycle without transfer, no matter how the scan data and masks change.
- R5: Check bit i, registered one cycle after the inputs, equals the parity of (chk_mask[i*16 +: 16] AND shadow), using the mask and the shadow value present before that edge.
- R6: `chk_valid` rises one cycle after the first transfer has been captured and then stays high until reset.
- R7: For a window holding unknown bits, a mask orthogonal to the signature response of every unknown bit yields a check bit that is independent of the unknown values. It equals the parity that is computed with all unknowns set to 0.
- R8: All check channels are evaluated in the same cycle, each from its own mask field, with no interaction between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scan_in | input | N_CHAINS | One slice of scan chain outputs per cycle |
| xfer | input | 1 | Copy signature to shadow and restart the signature register |
| chk_mask | input | N_CHK*SIG_W | Concatenated selection masks, channel i in bits [i*SIG_W +: SIG_W] |
| chk_bits | output | N_CHK | Registered parity of each mask over the shadow register |
| chk_valid | output | 1 | High once the shadow register holds a transferred signature |

## Verification
The bench goes after the transfer boundary. A design that dropped the transfer-cycle slice, or put it into the outgoing signature, reads back a shadow word that is off in the bits that slice touches. Back-to-back transfers catch a design that copies the already-restarted register. Windows seeded with unknown bits are read out through masks found by searching for vectors orthogonal to each unknown's signature response. A wrong feedback tap or phase-shift index leaves those check bits dependent on the random unknown values, so they miss the zero-unknown parity. Unit-mask readback over many non-transfer cycles exposes a shadow register that leaks updates, and the first cycles after reset catch a valid flag that comes up early.

// File: rtl/xc_pkg.sv
package xc_pkg;
  // Feedback taps of x^16 + x^14 + x^13 + x^11 + 1 on a left-shifting register
  localparam logic [15:0] XC_POLY16 = 16'hB400;

  // Second chain feeding phase-shifter output j
  function automatic int ps_tap_b(input int j, input int n);
    return (5 * j + 3) % n;
  endfunction
endpackage

// File: rtl/xc_phase_shift.sv
module xc_phase_shift #(
  parameter int N_CHAINS = 8,
  parameter int SIG_W    = 16
) (
  input  logic [N_CHAINS-1:0] chains_i,
  output logic [SIG_W-1:0]    ps_o
);
  for (genvar j = 0; j < SIG_W; j++) begin : g_out
    localparam int TAP_A = j % N_CHAINS;
    localparam int TAP_B = xc_pkg::ps_tap_b(j, N_CHAINS);
    if (TAP_A == TAP_B) begin : g_single
      assign ps_o[j] = chains_i[TAP_A];
    end else begin : g_pair
      assign ps_o[j] = chains_i[TAP_A] ^ chains_i[TAP_B];
    end
  end
endmodule

// File: rtl/xc_misr.sv
module xc_misr #(
  parameter int               SIG_W = 16,
  parameter logic [SIG_W-1:0] POLY  = 16'hB400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [SIG_W-1:0] ps_i,
  output logic [SIG_W-1:0] sig_o
);
  logic [SIG_W-1:0] sig_q, sig_d;

  always_comb begin
    if (restart_i) sig_d = ps_i;
    else           sig_d = {sig_q[SIG_W-2:0], ^(sig_q & POLY)} ^ ps_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_d;
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/xc_check_net.sv
module xc_check_net #(
  parameter int SIG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SIG_W-1:0] mask_i,
  input  logic [SIG_W-1:0] shadow_i,
  output logic             bit_o
);
  logic bit_d, bit_q;

  always_comb bit_d = ^(mask_i & shadow_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/xc_shadow_compactor.sv
module xc_shadow_compactor #(
  parameter int               N_CHAINS = 8,
  parameter int               SIG_W    = 16,
  parameter int               N_CHK    = 2,
  parameter logic [SIG_W-1:0] POLY     = xc_pkg::XC_POLY16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CHAINS-1:0]      scan_in,
  input  logic                     xfer,
  input  logic [N_CHK*SIG_W-1:0]   chk_mask,
  output logic [N_CHK-1:0]         chk_bits,
  output logic                     chk_valid
);
  localparam int MASK_W = N_CHK * SIG_W;

  logic [1:0]       rst_pipe_q;
  logic             rst_n_int;
  logic [SIG_W-1:0] ps_vec;
  logic [SIG_W-1:0] misr_sig;
  logic [SIG_W-1:0] shadow_q, shadow_d;
  logic             shadow_vld_q, shadow_vld_d;
  logic             chk_valid_q;

  // Reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  xc_phase_shift #(.N_CHAINS(N_CHAINS), .SIG_W(SIG_W)) u_ps (
    .chains_i (scan_in),
    .ps_o     (ps_vec)
  );

  xc_misr #(.SIG_W(SIG_W), .POLY(POLY)) u_misr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .restart_i (xfer),
    .ps_i      (ps_vec),
    .sig_o     (misr_sig)
  );

  always_comb begin
    shadow_d     = xfer ? misr_sig : shadow_q;
    shadow_vld_d = shadow_vld_q | xfer;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      shadow_q     <= '0;
      shadow_vld_q <= 1'b0;
      chk_valid_q  <= 1'b0;
    end else begin
      shadow_q     <= shadow_d;
      shadow_vld_q <= shadow_vld_d;
      chk_valid_q  <= shadow_vld_q;
    end
  end

  for (genvar i = 0; i < N_CHK; i++) begin : g_chk
    xc_check_net #(.SIG_W(SIG_W)) u_net (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .mask_i   (chk_mask[i*SIG_W +: SIG_W]),
      .shadow_i (shadow_q),
      .bit_o    (chk_bits[i])
    );
  end

  assign chk_valid = chk_valid_q;

  if (MASK_W != N_CHK * SIG_W) begin : g_bad_cfg
    $error("mask width mismatch");
  end
endmodule

// File: rtl/xc_shadow_compactor_chk.sv
module xc_shadow_compactor_chk #(
  parameter int SIG_W = 16,
  parameter int N_CHK = 2
) (
  input logic                   clk,
  input logic                   rst_ni,
  input logic                   xfer,
  input logic [SIG_W-1:0]       ps_vec,
  input logic [SIG_W-1:0]       misr_sig,
  input logic [SIG_W-1:0]       shadow_q,
  input logic [N_CHK*SIG_W-1:0] chk_mask,
  input logic [N_CHK-1:0]       chk_bits,
  input logic                   chk_valid
);
  // R1: until a signature is held, no check bit is set
  assert_idle_bits_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !chk_valid |-> chk_bits == '0);

  // R3: shadow captures the pre-edge signature
  assert_xfer_copy_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    xfer |=> shadow_q == $past(misr_sig));

  // R3: the transfer-cycle slice starts the new window
  assert_misr_restart_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    xfer |=> misr_sig == $past(ps_vec));

  // R4: no transfer, no change
  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    !xfer |=> $stable(shadow_q));

  // R6: valid never drops outside reset
  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    chk_valid |=> chk_valid);

  // R5 / R8: each channel is the parity of its own mask over the shadow
  for (genvar i = 0; i < N_CHK; i++) begin : g_par
    assert_chk_parity_R5: assert property (@(posedge clk) disable iff (!rst_ni)
      rst_ni |=> chk_bits[i] == ^($past(chk_mask[i*SIG_W +: SIG_W]) & $past(shadow_q)));
  end
endmodule

bind xc_shadow_compactor xc_shadow_compactor_chk #(.SIG_W(SIG_W), .N_CHK(N_CHK)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_n_int),
  .xfer      (xfer),
  .ps_vec    (ps_vec),
  .misr_sig  (misr_sig),
  .shadow_q  (shadow_q),
  .chk_mask  (chk_mask),
  .chk_bits  (chk_bits),
  .chk_valid (chk_valid)
);

// File: tb/xc_shadow_compactor_test.sv
module xc_shadow_compactor_test;
  localparam int NC = 8;
  localparam int SW = 16;
  localparam int NK = 2;
  localparam logic [SW-1:0] TAPS = 16'hB400;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic [NC-1:0]    scan;
  logic             xfer;
  logic [NK*SW-1:0] mask;
  logic [NK-1:0]    bits;
  logic             valid;

  xc_shadow_compactor uut (
    .clk(clk), .rst_n(rst_n), .scan_in(scan), .xfer(xfer),
    .chk_mask(mask), .chk_bits(bits), .chk_valid(valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [NK-1:0] bits;
    logic          vld;
    int            due;
    string         tag;
  } exp_t;
  exp_t sb[$];

  logic [SW-1:0] m_sig = '0;
  logic [SW-1:0] m_sh  = '0;
  logic          m_vld = 1'b0;

  // R2 phase-shift and signature recurrence
  function automatic logic [SW-1:0] ps_f(input logic [NC-1:0] c);
    logic [SW-1:0] r;
    for (int j = 0; j < SW; j++) r[j] = c[j % NC] ^ c[(5 * j + 3) % NC];
    return r;
  endfunction

  function automatic logic [SW-1:0] step_f(input logic [SW-1:0] s, input logic [NC-1:0] c);
    return {s[SW-2:0], ^(s & TAPS)} ^ ps_f(c);
  endfunction

  task automatic check(input string tag, input logic [NK:0] got, input logic [NK:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {valid,bits} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [NC-1:0] c, input logic x,
                       input logic [SW-1:0] k0, input logic [SW-1:0] k1,
                       input string tag, input bit ovr, input logic [NK-1:0] ovr_bits);
    exp_t e;
    scan = c; xfer = x; mask = {k1, k0};
    e.bits[0] = ^(k0 & m_sh);
    e.bits[1] = ^(k1 & m_sh);
    if (ovr) e.bits = ovr_bits;
    e.vld = m_vld;
    e.due = cyc + 1;
    e.tag = tag;
    sb.push_back(e);
    if (x) begin
      m_sh  = m_sig;
      m_vld = 1'b1;
      m_sig = ps_f(c);
    end else begin
      m_sig = step_f(m_sig, c);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops expected items once their edge has passed
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb.size() > 0 && sb[0].due <= cyc) begin
        e = sb.pop_front();
        check(e.tag, {valid, bits}, {e.vld, e.bits});
      end
    end
  end

  task automatic readback(input string tag);
    for (int j = 0; j < SW / 2; j++)
      drive(NC'($urandom), 1'b0, SW'(1) << (2 * j), SW'(1) << (2 * j + 1), tag, 1'b0, '0);
  endtask

  // R7: window with unknown bits, read through X-canceling masks
  task automatic x_window();
    localparam int W = 10;
    localparam int NX = 5;
    logic [NC-1:0] base [W];
    logic [NC-1:0] xm   [W];
    logic [SW-1:0] ev   [NX];
    logic [SW-1:0] s0, s, mk0, mk1;
    int nf;
    for (int c = 0; c < W; c++) begin
      base[c] = NC'($urandom);
      xm[c]   = '0;
    end
    for (int i = 0; i < NX; i++) begin
      int cc, bb;
      cc = $urandom_range(0, W - 1);
      bb = $urandom_range(0, NC - 1);
      while (xm[cc][bb]) begin
        cc = $urandom_range(0, W - 1);
        bb = $urandom_range(0, NC - 1);
      end
      xm[cc][bb] = 1'b1;
      s = '0;
      for (int c = 0; c < W; c++) s = step_f(s, (c == cc) ? (NC'(1) << bb) : NC'(0));
      ev[i] = s;
    end
    for (int c = 0; c < W; c++) base[c] = base[c] & ~xm[c];
    s0 = '0;
    for (int c = 0; c < W; c++) s0 = step_f(s0, base[c]);
    nf = 0; mk0 = '0; mk1 = '0;
    for (int mm = 1; mm < (1 << SW) && nf < 2; mm++) begin
      bit ok;
      ok = 1'b1;
      for (int i = 0; i < NX; i++) if (^(SW'(mm) & ev[i])) ok = 1'b0;
      if (ok && (^(SW'(mm) & s0) || mm > 255)) begin
        if (nf == 0) mk0 = SW'(mm); else mk1 = SW'(mm);
        nf++;
      end
    end
    for (int c = 0; c < W; c++)
      drive(base[c] | (xm[c] & NC'($urandom)), c == 0, '0, '0, "R7 fill", 1'b0, '0);
    drive(NC'($urandom), 1'b1, '0, '0, "R7 close", 1'b0, '0);
    drive(NC'($urandom), 1'b0, mk0, mk1, "R7 cancel", 1'b1, {^(mk1 & s0), ^(mk0 & s0)});
    drive(NC'($urandom), 1'b0, mk1, mk0, "R7 R8 swapped", 1'b1, {^(mk0 & s0), ^(mk1 & s0)});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: got no completion, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; scan = '0; xfer = 1'b0; mask = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {valid, bits}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", {valid, bits}, '0);

    // R6: no transfer yet, valid low, all-ones masks read zeros
    for (int i = 0; i < 4; i++)
      drive(NC'($urandom), 1'b0, '1, '1, "R6 R1 pre-transfer", 1'b0, '0);

    // First window
    drive(NC'($urandom), 1'b1, '0, '0, "R6 first transfer", 1'b0, '0);
    for (int i = 0; i < 12; i++) drive(NC'($urandom), 1'b0, '0, '0, "R2 fill", 1'b0, '0);
    drive(NC'($urandom), 1'b1, '0, '0, "R3 transfer", 1'b0, '0);
    readback("R2 R3 R4 readback");
    readback("R4 held");

    // R3: back-to-back transfers
    drive(8'hA5, 1'b1, '0, '0, "R3 b2b first", 1'b0, '0);
    drive(8'h3C, 1'b1, '0, '0, "R3 b2b second", 1'b0, '0);
    readback("R3 back-to-back");

    // R5/R8: random masks on both channels
    for (int i = 0; i < 12; i++)
      drive(NC'($urandom), 1'b0, SW'($urandom), SW'($urandom), "R5 R8 random masks", 1'b0, '0);

    x_window();
    x_window();
    readback("R2 R4 after X windows");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule